// File: doc/BRIEF.md
# General-Purpose I/O Bank Register Port

This block is one bank of general-purpose I/O lines placed behind a small synchronous register port that is addressed by word. It holds a direction bit and an output-latch bit for each line and drives the pad output value and the pad output enable from them. Software can set or clear individual output bits in one write, through separate write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. It can also replace the whole latch with a single write.

Pad inputs pass through a multi-flop synchronizer. The synchronized level can be read back through the input word for every line, including lines that are being driven as outputs. The same level is also presented on a port, so that a separate edge-interrupt block can use it. Because of the synchronizer, a read issued right after a pad change returns the earlier level.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held (synchronous, active high), every direction bit becomes 1 and every output-latch bit becomes 0. After reset, all pad output enables are 0 and the read data is 0.
- R2: Word 0 holds the direction bits and is read/write. A direction bit of 1 makes the line an input. A direction bit of 0 makes it an output. Each pad output enable is 1 exactly when the line's direction bit is 0.
- R3: Word 1 holds the output latch. A write to it replaces the whole latch, a read returns it, and the pad output value equals the latch on every line.
- R4: A write to word 2 sets every latch bit whose write-data bit is 1 and leaves every other latch bit unchanged.
- R5: A write to word 3 clears every latch bit whose write-data bit is 1 and leaves every other latch bit unchanged.
- R6: A read of word 4 returns the synchronized pad level of every line, whether the line is an input or an output.
- R7: A pad change becomes visible on the synchronized level, and in word 4, on the second rising clock edge after it. A read sampled at the first edge still returns the old level.
- R8: A write to word 4, or to any address of 5 or above, changes neither the direction bits nor the latch. A read of an address of 5 or above returns 0.
- R9: Read data is registered. It takes the addressed word at the clock edge where the read strobe is high and holds its value in every cycle without a read strobe.
- R10: The synchronized pad level is also driven on an output port for use by edge-detection logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (4) | Word address |
| reg_wdata | input | WIDTH (32) | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | WIDTH (32) | Registered read data |
| pad_in | input | WIDTH (32) | Raw pad input levels |
| pad_out | output | WIDTH (32) | Pad output values (output latch) |
| pad_oe | output | WIDTH (32) | Pad output enables, 1 = drive |
| pad_level_sync | output | WIDTH (32) | Synchronized pad levels |

## Verification
On every cycle, the assertions check how the latch updates for set, clear and direct writes. They also check that the latch and direction bits stay put when no write targets them, the reset values, the stage-by-stage progress of the synchronizer, and that read data holds between reads. The bench's scenarios show the rest at the ports: how word 4 reads back driven outputs, that the new level does not appear after one edge and does appear after two, that unmapped reads return zero, and that writes to the input word or to unmapped addresses have no effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned WORD_COUNT = 5;
    localparam int unsigned WORD_IDX_W = 3;

    typedef enum logic [WORD_IDX_W-1:0] {
        W_DIR  = 3'd0,
        W_DOUT = 3'd1,
        W_SET  = 3'd2,
        W_CLR  = 3'd3,
        W_DIN  = 3'd4
    } word_e;

    typedef struct packed {
        logic wr_dir;
        logic wr_dout;
        logic wr_set;
        logic wr_clr;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic wr, input logic hit,
                                             input logic [WORD_IDX_W-1:0] idx);
        wr_dec_t d;
        d = '0;
        if (wr && hit) begin
            case (idx)
                W_DIR:   d.wr_dir  = 1'b1;
                W_DOUT:  d.wr_dout = 1'b1;
                W_SET:   d.wr_set  = 1'b1;
                W_CLR:   d.wr_clr  = 1'b1;
                default: d = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic             live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q[0] <= '0;
        else     stg_q[0] <= raw_i;
    end

    a_r7_first_stage: assert property (@(posedge clk) disable iff (rst)
        live_q |-> stg_q[0] == $past(raw_i));

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_q[s] <= '0;
            else     stg_q[s] <= stg_q[s-1];
        end
        a_r7_stage_shift: assert property (@(posedge clk) disable iff (rst)
            live_q |-> stg_q[s] == $past(stg_q[s-1]));
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_dec_t          wdec,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q
);
    logic live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)              dir_q <= '1;
        else if (wdec.wr_dir) dir_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)               latch_q <= '0;
        else if (wdec.wr_dout) latch_q <= wdata;
        else if (wdec.wr_set)  latch_q <= latch_q | wdata;
        else if (wdec.wr_clr)  latch_q <= latch_q & ~wdata;
    end

    a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
        !live_q |-> (dir_q == '1 && latch_q == '0));
    a_r3_direct: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(wdec.wr_dout) |-> latch_q == $past(wdata));
    a_r4_set_only_ones: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(wdec.wr_set) |-> latch_q == ($past(latch_q) | $past(wdata)));
    a_r5_clr_only_ones: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(wdec.wr_clr) |-> latch_q == ($past(latch_q) & ~$past(wdata)));
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
        live_q && !$past(wdec.wr_dout || wdec.wr_set || wdec.wr_clr) |-> $stable(latch_q));
    a_r8_dir_hold: assert property (@(posedge clk) disable iff (rst)
        live_q && !$past(wdec.wr_dir) |-> $stable(dir_q));
    a_r8_onehot_dec: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wdec));
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd,
    input  logic                  hit,
    input  logic [WORD_IDX_W-1:0] idx,
    input  logic [WIDTH-1:0]      dir_i,
    input  logic [WIDTH-1:0]      latch_i,
    input  logic [WIDTH-1:0]      level_i,
    output logic [WIDTH-1:0]      rdata_q
);
    logic [WIDTH-1:0] sel;
    logic             live_q;

    always_comb begin
        sel = '0;
        if (hit) begin
            case (idx)
                W_DIR:   sel = dir_i;
                W_DOUT:  sel = latch_i;
                W_DIN:   sel = level_i;
                default: sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (rd) rdata_q <= sel;
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        live_q && !$past(rd) |-> $stable(rdata_q));
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(rd) && !$past(hit) |-> rdata_q == '0);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_level_sync
);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(WORD_COUNT - 1);

    logic                  hit;
    logic [WORD_IDX_W-1:0] idx;
    wr_dec_t               wdec;
    logic [WIDTH-1:0]      dir_q;
    logic [WIDTH-1:0]      latch_q;

    assign hit  = (reg_addr <= LAST_WORD);
    assign idx  = reg_addr[WORD_IDX_W-1:0];
    assign wdec = decode_write(reg_wr, hit, idx);

    gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pad_in),
        .sync_o (pad_level_sync)
    );

    gpio_out_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wdec    (wdec),
        .wdata   (reg_wdata),
        .dir_q   (dir_q),
        .latch_q (latch_q)
    );

    gpio_read_port #(.WIDTH(WIDTH)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (reg_rd),
        .hit     (hit),
        .idx     (idx),
        .dir_i   (dir_q),
        .latch_i (latch_q),
        .level_i (pad_level_sync),
        .rdata_q (reg_rdata)
    );

    assign pad_out = latch_q;
    assign pad_oe  = ~dir_q;

    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (rst)
        wdec.wr_dir |=> pad_oe == ~$past(reg_wdata));
endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_level_sync;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_level_sync(pad_level_sync)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [3:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [3:0] a, output logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        check("R1 oe", pad_oe, '0);
        check("R1 out", pad_out, '0);
        check("R1 rdata", reg_rdata, '0);
        rd_word(4'd0, v); check("R1 dir", v, '1);
    endtask

    task automatic t_direction;
        logic [W-1:0] v;
        wr_word(4'd0, 32'hFFFF_00F0);
        check("R2 oe", pad_oe, 32'h0000_FF0F);
        rd_word(4'd0, v); check("R2 readback", v, 32'hFFFF_00F0);
    endtask

    task automatic t_direct;
        logic [W-1:0] v;
        wr_word(4'd1, 32'hA5A5_0F0F);
        check("R3 pad_out", pad_out, 32'hA5A5_0F0F);
        wr_word(4'd1, 32'h1234_5678);
        rd_word(4'd1, v); check("R3 replace", v, 32'h1234_5678);
    endtask

    task automatic t_set;
        wr_word(4'd1, 32'h0000_00F0);
        wr_word(4'd2, 32'h8000_0003);
        check("R4 set", pad_out, 32'h8000_00F3);
        wr_word(4'd2, 32'h0);
        check("R4 zero set", pad_out, 32'h8000_00F3);
    endtask

    task automatic t_clear;
        wr_word(4'd3, 32'h8000_0011);
        check("R5 clear", pad_out, 32'h0000_00E2);
        wr_word(4'd3, 32'h0);
        check("R5 zero clear", pad_out, 32'h0000_00E2);
    endtask

    task automatic t_input_read;
        logic [W-1:0] v;
        wr_word(4'd0, 32'h0000_FFFF);   // upper half outputs
        @(negedge clk); pad_in = 32'hCAFE_1234;
        repeat (3) @(negedge clk);
        rd_word(4'd4, v); check("R6 din incl outputs", v, 32'hCAFE_1234);
        check("R10 sync port", pad_level_sync, 32'hCAFE_1234);
    endtask

    task automatic t_latency;
        logic [W-1:0] v;
        @(negedge clk); pad_in = 32'h0F0F_0F0F;
        @(negedge clk);
        check("R7 one edge old", pad_level_sync, 32'hCAFE_1234);
        @(negedge clk);
        check("R7 two edges new", pad_level_sync, 32'h0F0F_0F0F);
        @(negedge clk); pad_in = 32'h5555_AAAA;
        reg_addr = 4'd4; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
        check("R7 early read old", v, 32'h0F0F_0F0F);
    endtask

    task automatic t_ignored;
        logic [W-1:0] v, d0, l0;
        rd_word(4'd0, d0); rd_word(4'd1, l0);
        wr_word(4'd4, 32'hDEAD_BEEF);
        wr_word(4'd5, 32'hDEAD_BEEF);
        wr_word(4'd15, 32'hFFFF_FFFF);
        check("R8 latch kept", pad_out, l0);
        check("R8 oe kept", pad_oe, ~d0);
        rd_word(4'd0, v); check("R8 dir kept", v, d0);
        rd_word(4'd7, v); check("R8 unmapped read", v, '0);
    endtask

    task automatic t_hold;
        logic [W-1:0] v;
        rd_word(4'd1, v);
        wr_word(4'd1, 32'h0BAD_F00D);
        check("R9 hold", reg_rdata, v);
        rd_word(4'd1, v); check("R9 new read", v, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direction();
        t_direct();
        t_set();
        t_clear();
        t_input_read();
        t_latency();
        t_ignored();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule